// File: doc/BRIEF.md
# SDRAM Mode Register Command Checker

This block observes mode register load commands as they are issued to a DDR SDRAM device and sorts each address word into one of three classes: normal operation, delay-locked-loop reset, or reserved. The device-size select sets how many upper address bits take part in the decode. When a command is not reserved, the settings field (address bits 6 down to 0) is copied into a shadow register. When it is reserved, the shadow register keeps its old value and a sticky error flag is set.

The block also checks two usage rules. The first rule is about sequencing. After a DLL reset, the next mode register command should choose normal operation. The second rule is about CAS latency. The CAS latency held in the shadow register must be legal at the clock frequency supplied in MHz. These checks report through flags only. Producing the commands themselves is the job of other logic.

Top module: `sdram_mode_checker`

## Requirements
- R1: When `cmd_valid` is high, the command is classified from the upper bits. With `size_large`=0 the upper bits are A7..A11; with `size_large`=1 they are A7..A12. All upper bits zero gives class 0 (normal). A8=1 with every other upper bit zero gives class 1 (DLL reset). Any other pattern gives class 2 (reserved). `mode_class` shows the result one cycle after the command and holds it until the next command. After reset it reads 0.
- R2: A normal or DLL-reset command loads A6..A0 into `shadow_q` one cycle later. A reserved command leaves `shadow_q` unchanged. The reset value of `shadow_q` is 0.
- R3: A reserved command sets `reserved_err`. The flag is sticky: only reset clears it.
- R4: A DLL-reset command raises `dll_reset_pulse` for exactly one cycle, the cycle after the command. No other command raises it.
- R5: When the previous mode register command was a DLL reset and the current command is a DLL reset or a reserved command, `seq_err` goes high the next cycle. A normal command clears `seq_err`.
- R6: The CAS latency code is `shadow_q[6:4]`. Codes 010, 110 and 011 stand for CL 2, 2.5 and 3. Any other code drives `cl_invalid` high. The flag is evaluated each cycle from the shadow register and is registered.
- R7: `freq_err` is high when a valid CL lies outside its window. The windows are 75..133 MHz for CL 2, 75..167 MHz for CL 2.5 and 125..200 MHz for CL 3. The flag is evaluated each cycle from `shadow_q` and `freq_mhz`, so it follows a change in either with one cycle of registering. When `cl_invalid` is high, `freq_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Mode register load command strobe |
| cmd_addr | input | 13 | Address word carried with the command |
| size_large | input | 1 | 1 adds A12 to the upper mode bits |
| freq_mhz | input | 9 | Clock frequency in MHz |
| mode_class | output | 2 | Class of last command: 0 normal, 1 DLL reset, 2 reserved |
| shadow_q | output | 7 | Stored operating settings |
| dll_reset_pulse | output | 1 | One-cycle pulse after a DLL reset command |
| reserved_err | output | 1 | Sticky reserved-pattern error |
| seq_err | output | 1 | DLL reset not followed by normal mode |
| cl_invalid | output | 1 | CAS latency code is not legal |
| freq_err | output | 1 | Legal CAS latency used outside its frequency window |

## Verification
A fault in the decoder shows up at the ports in three places. The class is wrong one cycle after the command. The shadow register is updated or skipped when it should not be. The DLL pulse is missing or spurious. A lost record of the pending DLL reset shows up as a `seq_err` that does not match the next command, again one cycle later. A wrong latency or window decode shows up as wrong `cl_invalid` or `freq_err` one cycle after `shadow_q` or `freq_mhz` changes. The frequency sweep covers every window edge, so an off-by-one boundary shows up right away.

// File: rtl/sdram_mode_pkg.sv
package sdram_mode_pkg;
  localparam int ADDR_W = 13;
  localparam int SET_W  = 7;
  localparam int FREQ_W = 9;

  typedef enum logic [1:0] {
    MC_NORMAL   = 2'd0,
    MC_DLL_RST  = 2'd1,
    MC_RESERVED = 2'd2
  } mode_class_t;

  typedef enum logic [1:0] {
    CL_NONE = 2'd0,
    CL_2    = 2'd1,
    CL_25   = 2'd2,
    CL_3    = 2'd3
  } cas_t;

  function automatic cas_t decode_cas(input logic [2:0] code);
    case (code)
      3'b010:  decode_cas = CL_2;
      3'b110:  decode_cas = CL_25;
      3'b011:  decode_cas = CL_3;
      default: decode_cas = CL_NONE;
    endcase
  endfunction

  function automatic logic freq_in_window(input cas_t cl, input logic [FREQ_W-1:0] f);
    case (cl)
      CL_2:    freq_in_window = (f >= 9'd75)  && (f <= 9'd133);
      CL_25:   freq_in_window = (f >= 9'd75)  && (f <= 9'd167);
      CL_3:    freq_in_window = (f >= 9'd125) && (f <= 9'd200);
      default: freq_in_window = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/mode_classifier.sv
module mode_classifier
  import sdram_mode_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              size_large,
  output mode_class_t       cls
);
  logic [5:0] upper;
  logic       a12_used;

  always_comb begin
    a12_used = size_large & addr[12];
    upper    = {a12_used, addr[11:7]};
    if (upper == 6'b0)
      cls = MC_NORMAL;
    else if (upper == 6'b000010)
      cls = MC_DLL_RST;
    else
      cls = MC_RESERVED;
  end
endmodule

// File: rtl/mode_seq_tracker.sv
module mode_seq_tracker
  import sdram_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  mode_class_t cls,
  output logic        seq_err
);
  logic dll_pending;
  logic seq_violate;

  assign seq_violate = cmd_valid && dll_pending && (cls != MC_NORMAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dll_pending <= 1'b0;
      seq_err     <= 1'b0;
    end else if (cmd_valid) begin
      dll_pending <= (cls == MC_DLL_RST);
      if (cls == MC_NORMAL)
        seq_err <= 1'b0;
      else if (seq_violate)
        seq_err <= 1'b1;
    end
  end

  p_seq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_violate |=> seq_err);
  p_seq_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cls == MC_NORMAL) |=> !seq_err);
endmodule

// File: rtl/cas_freq_check.sv
module cas_freq_check
  import sdram_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cl_code,
  input  logic [FREQ_W-1:0] freq,
  output logic              cl_invalid,
  output logic              freq_err
);
  cas_t cl_now;
  logic in_win;

  assign cl_now = decode_cas(cl_code);
  assign in_win = freq_in_window(cl_now, freq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cl_invalid <= 1'b0;
      freq_err   <= 1'b0;
    end else begin
      cl_invalid <= (cl_now == CL_NONE);
      freq_err   <= (cl_now != CL_NONE) && !in_win;
    end
  end

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cl_invalid && freq_err));
endmodule

// File: rtl/sdram_mode_checker.sv
module sdram_mode_checker
  import sdram_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              size_large,
  input  logic [FREQ_W-1:0] freq_mhz,
  output logic [1:0]        mode_class,
  output logic [SET_W-1:0]  shadow_q,
  output logic              dll_reset_pulse,
  output logic              reserved_err,
  output logic              seq_err,
  output logic              cl_invalid,
  output logic              freq_err
);
  mode_class_t cls_now;
  mode_class_t cls_q;
  logic        take_settings;
  logic        is_reserved;

  mode_classifier u_cls (
    .addr(cmd_addr), .size_large(size_large), .cls(cls_now)
  );

  assign is_reserved   = cmd_valid && (cls_now == MC_RESERVED);
  assign take_settings = cmd_valid && (cls_now != MC_RESERVED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cls_q           <= MC_NORMAL;
      shadow_q        <= '0;
      dll_reset_pulse <= 1'b0;
      reserved_err    <= 1'b0;
    end else begin
      dll_reset_pulse <= cmd_valid && (cls_now == MC_DLL_RST);
      if (cmd_valid)     cls_q <= cls_now;
      if (take_settings) shadow_q <= cmd_addr[SET_W-1:0];
      if (is_reserved)   reserved_err <= 1'b1;
    end
  end

  assign mode_class = cls_q;

  mode_seq_tracker u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cls(cls_now), .seq_err(seq_err)
  );

  cas_freq_check u_cas (
    .clk(clk), .rst_n(rst_n), .cl_code(shadow_q[6:4]), .freq(freq_mhz),
    .cl_invalid(cl_invalid), .freq_err(freq_err)
  );

  p_class_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_class != 2'd3);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_reserved |=> $stable(shadow_q));
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_err |=> reserved_err);
  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dll_reset_pulse |=> !dll_reset_pulse || $past(cmd_valid));
  p_pulse_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dll_reset_pulse |-> mode_class == 2'd1);
endmodule

// File: tb/sdram_mode_checker_tb_top.sv
module sdram_mode_checker_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic cmd_valid = 0;
  logic [12:0] cmd_addr = 0;
  logic size_large = 0;
  logic [8:0] freq_mhz = 9'd100;
  logic [1:0] mode_class;
  logic [6:0] shadow_q;
  logic dll_reset_pulse, reserved_err, seq_err, cl_invalid, freq_err;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sdram_mode_checker dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_class(input logic [12:0] a, input logic big);
    int up;
    up = a[11:7];
    if (big) up = up | (int'(a[12]) << 5);
    if (up == 0) return 0;
    if (up == 2) return 1;
    return 2;
  endfunction

  function automatic int exp_ferr(input logic [2:0] c, input int f);
    if (c == 3'b010) return (f < 75 || f > 133) ? 1 : 0;
    if (c == 3'b110) return (f < 75 || f > 167) ? 1 : 0;
    if (c == 3'b011) return (f < 125 || f > 200) ? 1 : 0;
    return 0;
  endfunction

  task automatic issue(input logic [12:0] a);
    @(negedge clk);
    cmd_addr = a; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  int shadow_exp;
  int seq_exp;
  int pend;

  initial begin
    int c;
    repeat (3) @(negedge clk);
    chk("R1 reset class", mode_class, 0);
    chk("R2 reset shadow", shadow_q, 0);
    chk("R3 reset err", reserved_err, 0);
    rst_n = 1;
    shadow_exp = 0; seq_exp = 0; pend = 0;
    // Sweep upper bits for both sizes
    for (int big = 0; big < 2; big++) begin
      size_large = big[0];
      for (int up = 0; up < 64; up++) begin
        logic [12:0] a;
        a = {up[5:0], 7'(up * 5 + 3)};
        c = exp_class(a, big[0]);
        issue(a);
        chk("R1 class", mode_class, c);
        chk("R4 pulse", dll_reset_pulse, c == 1);
        if (c != 2) shadow_exp = a[6:0];
        chk("R2 shadow", shadow_q, shadow_exp);
        if (c == 0) seq_exp = 0;
        else if (pend) seq_exp = 1;
        pend = (c == 1);
        chk("R5 seq", seq_err, seq_exp);
        @(negedge clk);
        chk("R4 pulse width", dll_reset_pulse, 0);
        chk("R1 hold", mode_class, c);
      end
    end
    chk("R3 sticky", reserved_err, 1);
    // Explicit sequence cases
    size_large = 0;
    issue(13'h0000); chk("R5 clear", seq_err, 0);
    issue(13'h0100); chk("R5 dll ok", seq_err, 0);
    issue(13'h0100); chk("R5 dll dll", seq_err, 1);
    issue(13'h0022); chk("R5 normal clears", seq_err, 0);
    issue(13'h0100); issue(13'h0800); chk("R5 dll reserved", seq_err, 1);
    chk("R3 still set", reserved_err, 1);
    // CL / frequency sweep
    for (int code = 0; code < 8; code++) begin
      issue({6'b0, code[2:0], 4'h5});
      for (int f = 60; f <= 215; f++) begin
        @(negedge clk); freq_mhz = f[8:0];
        @(negedge clk);
        chk("R6 cl_invalid", cl_invalid,
            (code == 2 || code == 6 || code == 3) ? 0 : 1);
        chk("R7 freq_err", freq_err, exp_ferr(code[2:0], f));
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule